// File: doc/BRIEF.md
# Halfword Instruction Length Predecoder

This block sits in the fetch stage, ahead of the full instruction decoder, in a machine whose instructions are one, two or three 16-bit halfwords long and always start on a halfword boundary. Each cycle it may be given the leading halfword of the instruction at the current fetch address. It reads only the two most significant bits of that halfword to find the instruction length. It then moves its fetch address past the instruction, so that the start of the next instruction is known one cycle later. The full decoder does not need to try a decode at every halfword boundary.

The fetch address is held in an internal register that is visible on the `pc` port. When reset is asserted, this register is loaded from a reset-vector input. Bit 0 of the address is forced to zero. If the vector was odd, a sticky alignment error flag is raised. All results are registered. One cycle after an accepted halfword, the block reports the instruction address, its length in halfwords and the address of the next instruction. Opcode decoding beyond the length and any handling of branches are left to other logic.

Top module: `hwlen_predecode`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid` is cleared, `pc` is loaded with `rst_vector` with bit 0 forced to 0, `align_err` is loaded with `rst_vector[0]`, and `out_len`, `out_pc` and `out_next_pc` are cleared.
- R2: A halfword accepted with bits [15:14] equal to 00 is reported with `out_len` = 1 on the following cycle.
- R3: A halfword accepted with bits [15:14] equal to 01 or 10 is reported with `out_len` = 2 on the following cycle.
- R4: A halfword accepted with bits [15:14] equal to 11 is reported with `out_len` = 3 on the following cycle.
- R5: One cycle after a halfword is accepted, `out_valid` is 1, `out_pc` holds the `pc` value at acceptance, and both `out_next_pc` and `pc` equal that address plus twice the length, modulo 2^ADDR_W.
- R6: In a cycle where `hw_valid` is low, `out_valid` falls to 0 at the next edge, and `pc`, `out_len`, `out_pc` and `out_next_pc` keep their values.
- R7: Bits [13:0] of `hw_data` have no effect on any output.
- R8: Bit 0 of `pc` is always 0.
- R9: Once set, `align_err` stays at 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_vector | input | ADDR_W | Byte address loaded into the fetch register at reset |
| hw_valid | input | 1 | `hw_data` holds the leading halfword at `pc` |
| hw_data | input | HW_W | Leading halfword of the instruction |
| pc | output | ADDR_W | Current fetch address |
| out_valid | output | 1 | A length result is present this cycle |
| out_len | output | 2 | Instruction length in halfwords (1 to 3) |
| out_pc | output | ADDR_W | Address of the instruction just measured |
| out_next_pc | output | ADDR_W | Address of the following instruction |
| align_err | output | 1 | Sticky flag: the reset vector was odd |

## Verification
The bench drives two copies from the same stimulus: one with the default 32-bit address and one with a 6-bit address. The wide copy starts just below the top of the address space and shows that a three-halfword step wraps to a small address. The narrow copy wraps many times during ordinary runs of instructions, so carries out of the top bit and steps onto address zero are checked often. Both copies are given even and odd reset vectors, idle gaps between instructions, and halfwords whose low fourteen bits are all zeros or all ones.

// File: rtl/hwlen_pkg.sv
package hwlen_pkg;

  typedef enum logic [1:0] {
    LEN_NONE  = 2'd0,
    LEN_ONE   = 2'd1,
    LEN_TWO   = 2'd2,
    LEN_THREE = 2'd3
  } hw_len_e;

  // Length class taken from the two leading opcode bits only.
  function automatic hw_len_e len_of_code(input logic [1:0] code);
    hw_len_e r;
    unique case (code)
      2'b00:   r = LEN_ONE;
      2'b11:   r = LEN_THREE;
      default: r = LEN_TWO;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/hwlen_classify.sv
module hwlen_classify
  import hwlen_pkg::*;
#(
  parameter int HW_W = 16
) (
  input  logic [HW_W-1:0] hw,
  output hw_len_e         len
);
  localparam int CODE_HI = HW_W - 1;
  localparam int CODE_LO = HW_W - 2;

  logic [1:0] code;

  always_comb begin
    code = hw[CODE_HI:CODE_LO];
    len  = len_of_code(code);
  end
endmodule

// File: rtl/hwlen_adder.sv
module hwlen_adder
  import hwlen_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  hw_len_e           len,
  output logic [ADDR_W-1:0] sum
);
  localparam int PAD_W = ADDR_W - 3;

  logic [ADDR_W-1:0] step_bytes;

  always_comb begin
    step_bytes = {{PAD_W{1'b0}}, len, 1'b0};
    sum        = base + step_bytes;
  end
endmodule

// File: rtl/hwlen_pc_reg.sv
module hwlen_pc_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rst_vector,
  input  logic              adv,
  input  logic [ADDR_W-1:0] adv_addr,
  output logic [ADDR_W-1:0] pc_q,
  output logic              misalign_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q       <= {rst_vector[ADDR_W-1:1], 1'b0};
      misalign_q <= rst_vector[0];
    end else if (adv) begin
      pc_q <= {adv_addr[ADDR_W-1:1], 1'b0};
    end
  end
endmodule

// File: rtl/hwlen_predecode.sv
module hwlen_predecode
  import hwlen_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int HW_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rst_vector,
  input  logic              hw_valid,
  input  logic [HW_W-1:0]   hw_data,
  output logic [ADDR_W-1:0] pc,
  output logic              out_valid,
  output logic [1:0]        out_len,
  output logic [ADDR_W-1:0] out_pc,
  output logic [ADDR_W-1:0] out_next_pc,
  output logic              align_err
);
  hw_len_e           len_c;
  logic [ADDR_W-1:0] nxt_c;
  logic [ADDR_W-1:0] pc_q;
  logic              misalign_q;

  hwlen_classify #(.HW_W(HW_W)) u_cls (
    .hw  (hw_data),
    .len (len_c)
  );

  hwlen_adder #(.ADDR_W(ADDR_W)) u_add (
    .base (pc_q),
    .len  (len_c),
    .sum  (nxt_c)
  );

  hwlen_pc_reg #(.ADDR_W(ADDR_W)) u_pc (
    .clk        (clk),
    .rst        (rst),
    .rst_vector (rst_vector),
    .adv        (hw_valid),
    .adv_addr   (nxt_c),
    .pc_q       (pc_q),
    .misalign_q (misalign_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_len     <= LEN_NONE;
      out_pc      <= '0;
      out_next_pc <= '0;
    end else begin
      out_valid <= hw_valid;
      if (hw_valid) begin
        out_len     <= len_c;
        out_pc      <= pc_q;
        out_next_pc <= nxt_c;
      end
    end
  end

  assign pc        = pc_q;
  assign align_err = misalign_q;
endmodule

// File: rtl/hwlen_predecode_chk.sv
module hwlen_predecode_chk #(
  parameter int ADDR_W = 32,
  parameter int HW_W   = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] rst_vector,
  input logic              hw_valid,
  input logic [HW_W-1:0]   hw_data,
  input logic [ADDR_W-1:0] pc,
  input logic              out_valid,
  input logic [1:0]        out_len,
  input logic [ADDR_W-1:0] out_pc,
  input logic [ADDR_W-1:0] out_next_pc,
  input logic              align_err
);
  // R1
  reset_load_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && pc[ADDR_W-1:1] == $past(rst_vector[ADDR_W-1:1])
             && align_err == $past(rst_vector[0])));

  // R2
  len_one_chk: assert property (@(posedge clk) disable iff (rst)
    (hw_valid && hw_data[HW_W-1:HW_W-2] == 2'b00) |=> (out_len == 2'd1));

  // R3
  len_two_chk: assert property (@(posedge clk) disable iff (rst)
    (hw_valid && (hw_data[HW_W-1] ^ hw_data[HW_W-2])) |=> (out_len == 2'd2));

  // R4
  len_three_chk: assert property (@(posedge clk) disable iff (rst)
    (hw_valid && hw_data[HW_W-1:HW_W-2] == 2'b11) |=> (out_len == 2'd3));

  // R5
  next_addr_chk: assert property (@(posedge clk) disable iff (rst)
    hw_valid |=> (out_valid && out_pc == $past(pc) && pc == out_next_pc
                  && out_next_pc == ADDR_W'(out_pc + ADDR_W'({out_len, 1'b0}))));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !hw_valid |=> (!out_valid && $stable(pc) && $stable(out_len)
                   && $stable(out_pc) && $stable(out_next_pc)));

  // R8
  pc_even_chk: assert property (@(posedge clk) disable iff (rst)
    pc[0] == 1'b0);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    align_err |=> align_err);
endmodule

bind hwlen_predecode hwlen_predecode_chk #(.ADDR_W(ADDR_W), .HW_W(HW_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rst_vector  (rst_vector),
  .hw_valid    (hw_valid),
  .hw_data     (hw_data),
  .pc          (pc),
  .out_valid   (out_valid),
  .out_len     (out_len),
  .out_pc      (out_pc),
  .out_next_pc (out_next_pc),
  .align_err   (align_err)
);

// File: tb/sim_hwlen_predecode.sv
`timescale 1ns/1ps
module sim_hwlen_predecode;
  localparam int AW0 = 32;
  localparam int AW1 = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst = 1'b1;
  logic [AW0-1:0] vec0 = '0;
  logic [AW1-1:0] vec1 = '0;
  logic           hv = 1'b0;
  logic [15:0]    hd = '0;

  logic [AW0-1:0] pc0, opc0, onx0;
  logic [AW1-1:0] pc1, opc1, onx1;
  logic           ov0, ov1, er0, er1;
  logic [1:0]     ol0, ol1;

  hwlen_predecode #(.ADDR_W(AW0)) u0 (
    .clk(clk), .rst(rst), .rst_vector(vec0), .hw_valid(hv), .hw_data(hd),
    .pc(pc0), .out_valid(ov0), .out_len(ol0), .out_pc(opc0),
    .out_next_pc(onx0), .align_err(er0));

  hwlen_predecode #(.ADDR_W(AW1)) u1 (
    .clk(clk), .rst(rst), .rst_vector(vec1), .hw_valid(hv), .hw_data(hd),
    .pc(pc1), .out_valid(ov1), .out_len(ol1), .out_pc(opc1),
    .out_next_pc(onx1), .align_err(er1));

  // reference model state, index 0 = wide copy, index 1 = narrow copy
  longint m_pc[2], m_ipc[2], m_nx[2], m_len[2];
  bit     m_v[2], m_err[2];
  longint mask[2];
  int     n_cmp = 0;
  int     n_bad = 0;
  string  len_tag = "R2";
  bit     after_rst = 1'b0;

  function automatic longint ref_len(input bit [1:0] code);
    if (code == 2'b00) return 1;
    if (code == 2'b11) return 3;
    return 2;
  endfunction

  task automatic cmp(input string tag, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    longint apc[2], aipc[2], anx[2], alen[2];
    bit     av[2], aer[2];
    string  t;
    apc[0] = longint'(pc0);   apc[1] = longint'(pc1);
    aipc[0] = longint'(opc0); aipc[1] = longint'(opc1);
    anx[0] = longint'(onx0);  anx[1] = longint'(onx1);
    alen[0] = longint'(ol0);  alen[1] = longint'(ol1);
    av[0] = ov0; av[1] = ov1; aer[0] = er0; aer[1] = er1;
    for (int i = 0; i < 2; i++) begin
      t = after_rst ? "R1" : "R6";
      cmp(t, "out_valid", longint'(av[i]), longint'(m_v[i]));
      cmp(after_rst ? "R1" : "R5", "pc", apc[i], m_pc[i]);
      cmp(after_rst ? "R1" : "R5", "out_pc", aipc[i], m_ipc[i]);
      cmp(after_rst ? "R1" : "R5", "out_next_pc", anx[i], m_nx[i]);
      cmp(after_rst ? "R1" : len_tag, "out_len", alen[i], m_len[i]);
      cmp(after_rst ? "R1" : "R9", "align_err", longint'(aer[i]), longint'(m_err[i]));
      cmp("R8", "pc bit0", apc[i] & 1, 0);
    end
  endtask

  task automatic do_reset(input logic [AW0-1:0] v0, input logic [AW1-1:0] v1);
    @(negedge clk);
    rst = 1'b1; vec0 = v0; vec1 = v1; hv = 1'b0;
    @(posedge clk);
    m_pc[0] = longint'(v0) & ~64'sd1; m_err[0] = v0[0];
    m_pc[1] = longint'(v1) & ~64'sd1; m_err[1] = v1[0];
    for (int i = 0; i < 2; i++) begin
      m_v[i] = 1'b0; m_ipc[i] = 0; m_nx[i] = 0; m_len[i] = 0;
    end
    #5;
    after_rst = 1'b1;
    compare_all();
    after_rst = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(input bit v, input logic [15:0] d);
    @(negedge clk);
    hv = v; hd = d;
    @(posedge clk);
    for (int i = 0; i < 2; i++) begin
      m_v[i] = v;
      if (v) begin
        m_len[i] = ref_len(d[15:14]);
        m_ipc[i] = m_pc[i];
        m_nx[i]  = (m_pc[i] + 2 * m_len[i]) & mask[i];
        m_pc[i]  = m_nx[i];
      end
    end
    #5;
    compare_all();
  endtask

  function automatic string tag_of(input bit [1:0] c);
    if (c == 2'b00) return "R2";
    if (c == 2'b11) return "R4";
    return "R3";
  endfunction

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    join_none

    mask[0] = (64'sd1 <<< AW0) - 1;
    mask[1] = (64'sd1 <<< AW1) - 1;

    // R1: even reset vectors
    do_reset(32'h0000_1000, 6'd8);

    // R2 R3 R4: each length code with mixed low bits
    for (int k = 0; k < 4; k++) begin
      len_tag = tag_of(2'(k));
      step(1'b1, {2'(k), 14'h1234 + 14'(k * 977)});
    end

    // R6: idle gap holds state
    len_tag = "R6";
    step(1'b0, 16'hC000);
    step(1'b0, 16'h0000);

    // R7: low bits all ones versus all zeros for each code
    len_tag = "R7";
    for (int k = 0; k < 4; k++) begin
      step(1'b1, {2'(k), 14'h0000});
      step(1'b1, {2'(k), 14'h3FFF});
    end

    // long mixed run with gaps; narrow copy wraps repeatedly (R5)
    for (int k = 0; k < 200; k++) begin
      logic [15:0] d;
      d = 16'($urandom);
      len_tag = tag_of(d[15:14]);
      step((k % 7) != 3, d);
    end

    // R5: wide copy wraps past the top of the address space
    do_reset(32'hFFFF_FFFC, 6'd62);
    len_tag = "R4";
    step(1'b1, 16'hFFFF);
    len_tag = "R2";
    step(1'b1, 16'h0001);

    // R1 R9: odd reset vector sets a sticky error and even pc
    do_reset(32'h0000_2001, 6'd13);
    for (int k = 0; k < 12; k++) begin
      len_tag = tag_of(2'(k));
      step(k[0], {2'(k), 14'h2AAA});
    end

    // R1: a later even reset clears the error
    do_reset(32'h0000_4000, 6'd20);
    len_tag = "R3";
    step(1'b1, 16'h8000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule